// File: doc/BRIEF.md
# Parallel Camera Frame Capture Writer

This block sits behind the parallel pixel port of an image sensor. It runs on the sensor's data clock and stores one complete frame in a byte-addressed frame buffer through a single-cycle write port. A frame-boundary marker and a row-active marker come with the data bus. The block uses them to separate real pixel bytes from blanking and to lay the frame out linearly in memory. After a start request, the block waits for the next frame boundary. It then stores every pixel byte of that frame and raises a level flag once the final byte has been written.

The image geometry is picked at run time from a 2-bit size code and a colour/gray pin. Both are captured when the start request arrives. Gray frames use one byte per pixel. Colour frames use two bytes per pixel, in the 5-6-5 RGB packing the sensor sends. Bytes that fall outside the expected geometry are dropped: bytes past the end of a row, and bytes after the frame is complete. The buffer therefore always holds exactly width × height × bytes-per-pixel bytes, starting at address 0.

Top module: `dvp_frame_capture`

## Requirements
- R1: While `rst_ni` is low at a clock edge, `wr_en_o` and `frame_rcvd_o` are low after that edge.
- R2: A capture is armed by a rising edge on `init_i` or on `frame_req_i`, seen while idle or finished. Start edges seen while armed or capturing are ignored. Once armed, bytes are not written until a clock with `vd_i` high has been sampled, and storing begins after that clock.
- R3: Size code `size_sel_i` decodes as 00 = 128×96, 01 = 160×120, 10 = 320×240 and 11 = 640×480 pixels.
- R4: With `color_i` = 0 a pixel takes 1 byte; with `color_i` = 1 it takes 2 bytes. A byte's write address is (row × width + column) × bytes-per-pixel + byte index, counted from 0 at the start of each frame. The row stride is therefore width × bytes-per-pixel.
- R5: Only bytes sampled with `hd_i` high and `vd_i` low are written. A falling edge of `hd_i` closes the current row.
- R6: Bytes that arrive while `hd_i` is still high, after a row already holds its full width × bytes-per-pixel bytes, are not written.
- R7: `frame_rcvd_o` stays low while a capture is armed or running. It goes high in the same cycle that the write strobe for the frame's last byte appears, once width × height × bytes-per-pixel bytes have been written.
- R8: After completion, no further bytes are written and `frame_rcvd_o` stays high until the next start edge. That edge drops the flag one cycle later.
- R9: The size code and the colour pin are latched on the start edge. Changes to them during a capture do not change the frame geometry.
- R10: A `vd_i` high sample during a running capture restarts the frame: the next pixel byte is written at address 0, and the byte count starts again.
- R11: A pixel byte sampled at one clock edge appears on `wr_en_o`, `wr_addr_o` and `wr_data_o` after the next edge, with `wr_data_o` equal to the sampled byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor data clock; the pixel bus is sampled on its rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Start request; a rising edge arms a capture |
| frame_req_i | input | 1 | Repeat-frame request; a rising edge arms a capture |
| size_sel_i | input | 2 | Frame size code (see R3) |
| color_i | input | 1 | 1 = colour, 2 bytes per pixel; 0 = gray, 1 byte per pixel |
| vd_i | input | 1 | Frame boundary marker from the sensor |
| hd_i | input | 1 | Row-active marker; high while pixel bytes of a row are on the bus |
| data_i | input | DATA_W | Pixel byte bus |
| wr_en_o | output | 1 | Frame buffer write strobe |
| wr_addr_o | output | ADDR_W | Frame buffer byte address |
| wr_data_o | output | DATA_W | Frame buffer write data |
| frame_rcvd_o | output | 1 | High once the whole frame is stored |

## Verification
The store of the frame's final byte and the rise of the completion flag happen in the same cycle. The check is whether the flag rises together with the last write, rather than one cycle early or late. The bench sends full frames in gray and colour at two sizes. At the first cycle the flag reads high, it requires that a write strobe is present and that it carries address width × height × bytes-per-pixel − 1. It then sends more marker-high bytes after completion, and requires that the write count does not move while the flag stays set.

// File: rtl/dvp_cap_pkg.sv
// Package: shared types of the frame capture writer.
// Assumes: nothing beyond the standard language.
package dvp_cap_pkg;

    // Capture sequencing states
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_e;

    // Configuration captured on a start request
    typedef struct packed {
        logic [1:0] size;
        logic       color;
    } cap_cfg_t;

endpackage

// File: rtl/dvp_cap_geom.sv
// Module: dvp_cap_geom
// Turns the latched configuration into row length in bytes and row count.
// Assumes: cfg_i is stable during a capture; parameters fit COL_W/ROW_W
// (colour row of the widest size must fit COL_W).
module dvp_cap_geom
    import dvp_cap_pkg::*;
#(
    parameter int COL_W = 11,
    parameter int ROW_W = 9,
    parameter int W0    = 128,
    parameter int H0    = 96,
    parameter int W1    = 160,
    parameter int H1    = 120,
    parameter int W2    = 320,
    parameter int H2    = 240,
    parameter int W3    = 640,
    parameter int H3    = 480
) (
    input  cap_cfg_t          cfg_i,
    output logic [COL_W-1:0]  row_bytes_o,
    output logic [ROW_W-1:0]  rows_o
);

    logic [COL_W-1:0] width_px;

    // Select pixel width and row count from the size code
    always_comb begin
        case (cfg_i.size)
            2'b00:   begin width_px = COL_W'(W0); rows_o = ROW_W'(H0); end
            2'b01:   begin width_px = COL_W'(W1); rows_o = ROW_W'(H1); end
            2'b10:   begin width_px = COL_W'(W2); rows_o = ROW_W'(H2); end
            default: begin width_px = COL_W'(W3); rows_o = ROW_W'(H3); end
        endcase
    end

    // Colour doubles the bytes stored per row
    always_comb begin
        row_bytes_o = cfg_i.color ? (width_px << 1) : width_px;
    end

endmodule

// File: rtl/dvp_cap_ctrl.sv
// Module: dvp_cap_ctrl
// Sequences a capture: detects start edges, latches configuration, waits
// for the frame marker, runs until the last byte, then holds the done flag.
// Assumes: last_i pulses for one cycle only while run_o is high.
module dvp_cap_ctrl
    import dvp_cap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       init_i,
    input  logic       frame_req_i,
    input  logic [1:0] size_sel_i,
    input  logic       color_i,
    input  logic       vd_i,
    input  logic       last_i,
    output cap_cfg_t   cfg_o,
    output logic       run_o,
    output logic       frame_rcvd_o
);

    cap_state_e state_q;
    logic       init_q;
    logic       req_q;
    logic       start;

    // Remember previous request levels for edge detection
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            init_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            init_q <= init_i;
            req_q  <= frame_req_i;
        end
    end

    // A start is a rising edge on either request pin
    always_comb begin
        start = (init_i & ~init_q) | (frame_req_i & ~req_q);
    end

    // Capture state machine, configuration latch and completion flag
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q      <= CAP_IDLE;
            cfg_o        <= '0;
            frame_rcvd_o <= 1'b0;
        end else begin
            case (state_q)
                CAP_IDLE, CAP_DONE: begin
                    if (start) begin
                        state_q      <= CAP_ARMED;
                        cfg_o        <= '{size: size_sel_i, color: color_i};
                        frame_rcvd_o <= 1'b0;
                    end
                end
                CAP_ARMED: begin
                    if (vd_i) begin
                        state_q <= CAP_RUN;
                    end
                end
                CAP_RUN: begin
                    if (last_i) begin
                        state_q      <= CAP_DONE;
                        frame_rcvd_o <= 1'b1;
                    end
                end
                default: state_q <= CAP_IDLE;
            endcase
        end
    end

    // Counters run only in the capture state
    always_comb begin
        run_o = (state_q == CAP_RUN);
    end

endmodule

// File: rtl/dvp_cap_addr.sv
// Module: dvp_cap_addr
// Qualifies pixel bytes with the row marker, counts columns and rows,
// forms the linear byte address and registers the write port.
// Assumes: row_bytes_i >= 1 and rows_i >= 1, both stable while run_i is high.
module dvp_cap_addr #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 20,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              vd_i,
    input  logic              hd_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [COL_W-1:0]  row_bytes_i,
    input  logic [ROW_W-1:0]  rows_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              last_o
);

    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [ADDR_W-1:0] base_q;
    logic              hd_q;
    logic              row_full;
    logic              accept;
    logic              row_end;

    // Delayed row marker for falling-edge detection
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hd_q <= 1'b0;
        end else begin
            hd_q <= hd_i;
        end
    end

    // Byte qualification, row close and last-byte decode
    always_comb begin
        row_full = (col_q == row_bytes_i);
        accept   = run_i & hd_i & ~vd_i & ~row_full;
        row_end  = run_i & hd_q & ~hd_i & ~vd_i;
        last_o   = accept
                 & (row_q == rows_i - ROW_W'(1))
                 & (col_q == row_bytes_i - COL_W'(1));
    end

    // Column, row and row-base counters; cleared outside a run or on frame marker
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i || vd_i) begin
            col_q  <= '0;
            row_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            col_q <= col_q + COL_W'(1);
        end else if (row_end) begin
            col_q  <= '0;
            row_q  <= row_q + ROW_W'(1);
            base_q <= base_q + ADDR_W'(row_bytes_i);
        end
    end

    // Registered write port toward the frame buffer
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= accept;
            if (accept) begin
                wr_addr_o <= base_q + ADDR_W'(col_q);
                wr_data_o <= data_i;
            end
        end
    end

endmodule

// File: rtl/dvp_frame_capture.sv
// Module: dvp_frame_capture (top)
// Captures one frame from a parallel pixel port into a byte-addressed
// buffer; geometry and bytes per pixel come from pins latched at start.
// Assumes: every input is synchronous to clk_i, the sensor data clock.
module dvp_frame_capture
    import dvp_cap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 20,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 9,
    parameter int W0     = 128,
    parameter int H0     = 96,
    parameter int W1     = 160,
    parameter int H1     = 120,
    parameter int W2     = 320,
    parameter int H2     = 240,
    parameter int W3     = 640,
    parameter int H3     = 480
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              init_i,
    input  logic              frame_req_i,
    input  logic [1:0]        size_sel_i,
    input  logic              color_i,
    input  logic              vd_i,
    input  logic              hd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              frame_rcvd_o
);

    cap_cfg_t         cfg;
    logic             run;
    logic             last;
    logic [COL_W-1:0] row_bytes;
    logic [ROW_W-1:0] rows;

    dvp_cap_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .init_i       (init_i),
        .frame_req_i  (frame_req_i),
        .size_sel_i   (size_sel_i),
        .color_i      (color_i),
        .vd_i         (vd_i),
        .last_i       (last),
        .cfg_o        (cfg),
        .run_o        (run),
        .frame_rcvd_o (frame_rcvd_o)
    );

    dvp_cap_geom #(
        .COL_W (COL_W), .ROW_W (ROW_W),
        .W0 (W0), .H0 (H0), .W1 (W1), .H1 (H1),
        .W2 (W2), .H2 (H2), .W3 (W3), .H3 (H3)
    ) u_geom (
        .cfg_i       (cfg),
        .row_bytes_o (row_bytes),
        .rows_o      (rows)
    );

    dvp_cap_addr #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W),
        .COL_W  (COL_W),  .ROW_W  (ROW_W)
    ) u_addr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run),
        .vd_i        (vd_i),
        .hd_i        (hd_i),
        .data_i      (data_i),
        .row_bytes_i (row_bytes),
        .rows_i      (rows),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o),
        .last_o      (last)
    );

endmodule

// File: rtl/dvp_frame_capture_chk.sv
// Module: dvp_frame_capture_chk
// Port-level temporal checks for dvp_frame_capture, bound to every instance.
// Assumes: attached through the bind at the end of this file.
module dvp_frame_capture_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 20
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              vd_i,
    input logic              hd_i,
    input logic [DATA_W-1:0] data_i,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              frame_rcvd_o
);

    // R1: reset leaves the write strobe and flag low
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!wr_en_o && !frame_rcvd_o));

    // R5: a write needs a byte sampled with row marker high, frame marker low
    p_blank_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> ($past(hd_i) && !$past(vd_i)));

    // R11: written data is the byte sampled one edge earlier
    p_data_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (wr_data_o == $past(data_i)));

    // R4: back-to-back writes step the address by one byte
    p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)));

    // R7: the completion flag rises together with a write strobe
    p_rcvd_with_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frame_rcvd_o) |-> wr_en_o);

    // R8: no writes while the flag has been held high
    p_done_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_rcvd_o && $past(frame_rcvd_o)) |-> !wr_en_o);

endmodule

bind dvp_frame_capture dvp_frame_capture_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vd_i         (vd_i),
    .hd_i         (hd_i),
    .data_i       (data_i),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .frame_rcvd_o (frame_rcvd_o)
);

// File: tb/dvp_frame_capture_tb_top.sv
// Directed bench for dvp_frame_capture: one task per scenario.
module dvp_frame_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic        frame_req_i = 1'b0;
    logic [1:0]  size_sel_i = 2'b00;
    logic        color_i = 1'b0;
    logic        vd_i = 1'b0;
    logic        hd_i = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic        wr_en_o;
    logic [19:0] wr_addr_o;
    logic [7:0]  wr_data_o;
    logic        frame_rcvd_o;

    int checks = 0;
    int failures = 0;

    // Monitor state
    int          wr_cnt = 0;
    int          exp_addr = 0;
    bit          seq_en = 1'b0;
    int          seq_err = 0;
    bit          rcvd_prev = 1'b0;
    bit          rise_wr = 1'b0;
    int          rise_addr = -1;

    always #2 clk = ~clk;   // 250 MHz

    dvp_frame_capture dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .init_i       (init_i),
        .frame_req_i  (frame_req_i),
        .size_sel_i   (size_sel_i),
        .color_i      (color_i),
        .vd_i         (vd_i),
        .hd_i         (hd_i),
        .data_i       (data_i),
        .wr_en_o      (wr_en_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .frame_rcvd_o (frame_rcvd_o)
    );

    function automatic logic [7:0] pat(input int a);
        logic [31:0] v;
        v = a;
        return v[7:0] ^ v[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Observe the write port away from the active edge
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            wr_cnt++;
            if (seq_en && ((int'(wr_addr_o) != exp_addr) || (wr_data_o != pat(exp_addr))))
                seq_err++;
            exp_addr++;
        end
        if (rst_n && frame_rcvd_o && !rcvd_prev) begin
            rise_wr   = wr_en_o;
            rise_addr = int'(wr_addr_o);
        end
        rcvd_prev = rst_n && frame_rcvd_o;
    end

    task automatic step(input logic hd, input logic vd, input logic [7:0] d);
        @(negedge clk);
        hd_i   = hd;
        vd_i   = vd;
        data_i = d;
    endtask

    task automatic blank(input int n);
        repeat (n) step(1'b0, 1'b0, 8'h10);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; init_i = 1'b0; frame_req_i = 1'b0;
        hd_i = 1'b0; vd_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); frame_req_i = 1'b0;
        @(negedge clk); frame_req_i = 1'b1;
    endtask

    // Marker-high junk before the frame marker, then the marker and lead blanking
    task automatic lead_in();
        int c0;
        c0 = wr_cnt;
        repeat (4) step(1'b1, 1'b0, 8'h99);
        blank(2);
        chk(wr_cnt == c0, "R2", "bytes written before frame marker", wr_cnt - c0, 0);
        exp_addr = 0;
        step(1'b0, 1'b1, 8'h00);
        blank(3);
    endtask

    task automatic send_rows(input int rb, input int nrows, input int extra,
                             input int bl, input bit mid_chk);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < rb; c++) step(1'b1, 1'b0, pat(r * rb + c));
            for (int e = 0; e < extra; e++) step(1'b1, 1'b0, 8'hEE);
            blank(bl);
            if (mid_chk && r == 0)
                chk(frame_rcvd_o == 1'b0, "R7", "flag low during capture", frame_rcvd_o, 0);
        end
    endtask

    task automatic frame_end(input int base_cnt, input int total, input int last_a,
                             input string tag);
        blank(3);
        chk(wr_cnt - base_cnt == total, tag, "bytes written in frame", wr_cnt - base_cnt, total);
        chk(seq_err == 0, "R4", "address/data sequence mismatches", seq_err, 0);
        chk(frame_rcvd_o == 1'b1, "R7", "flag after last byte", frame_rcvd_o, 1);
        chk(rise_wr == 1'b1, "R7", "write strobe in flag rise cycle", rise_wr, 1);
        chk(rise_addr == last_a, "R7", "address at flag rise", rise_addr, last_a);
    endtask

    task automatic test_reset();
        do_reset();
        chk(wr_en_o == 1'b0, "R1", "write strobe after reset", wr_en_o, 0);
        chk(frame_rcvd_o == 1'b0, "R1", "flag after reset", frame_rcvd_o, 0);
    endtask

    // Gray 128x96 started by init
    task automatic test_gray_small();
        int b;
        b = wr_cnt; seq_en = 1'b1; seq_err = 0; rise_wr = 1'b0;
        size_sel_i = 2'b00; color_i = 1'b0;
        @(negedge clk); init_i = 1'b1;
        lead_in();
        send_rows(128, 96, 0, 2, 1'b1);
        frame_end(b, 12288, 12287, "R3");
    endtask

    // Colour 128x96 via frame request, config pins changed mid-capture
    task automatic test_colour_small();
        int b;
        b = wr_cnt; seq_err = 0; rise_wr = 1'b0;
        size_sel_i = 2'b00; color_i = 1'b1;
        pulse_req();
        @(negedge clk); size_sel_i = 2'b11; color_i = 1'b0;
        lead_in();
        pulse_req();   // R2: ignored while capturing
        send_rows(256, 96, 0, 2, 1'b1);
        frame_end(b, 24576, 24575, "R9");
    endtask

    // Gray 160x120 with row overrun bytes and trailing bytes after completion
    task automatic test_qqvga_overrun();
        int b;
        int c1;
        b = wr_cnt; seq_err = 0; rise_wr = 1'b0;
        size_sel_i = 2'b01; color_i = 1'b0;
        pulse_req();
        lead_in();
        send_rows(160, 120, 3, 2, 1'b0);
        frame_end(b, 19200, 19199, "R6");
        c1 = wr_cnt;
        repeat (20) step(1'b1, 1'b0, 8'h55);
        step(1'b0, 1'b1, 8'h00);
        repeat (5) step(1'b1, 1'b0, 8'h56);
        blank(2);
        chk(wr_cnt == c1, "R8", "writes after completion", wr_cnt - c1, 0);
        chk(frame_rcvd_o == 1'b1, "R8", "flag held after completion", frame_rcvd_o, 1);
        pulse_req();
        @(negedge clk);
        chk(frame_rcvd_o == 1'b0, "R8", "flag cleared by next start", frame_rcvd_o, 0);
    endtask

    // Frame marker mid-capture restarts addressing
    task automatic test_restart();
        int b;
        do_reset();
        b = wr_cnt; seq_err = 0; rise_wr = 1'b0;
        size_sel_i = 2'b00; color_i = 1'b0;
        @(negedge clk); init_i = 1'b1;
        lead_in();
        send_rows(128, 5, 0, 2, 1'b0);
        chk(frame_rcvd_o == 1'b0, "R10", "flag after partial frame", frame_rcvd_o, 0);
        exp_addr = 0;
        step(1'b0, 1'b1, 8'h00);
        blank(3);
        send_rows(128, 96, 0, 2, 1'b0);
        frame_end(b, 640 + 12288, 12287, "R10");
    endtask

    // Row stride and write latency with a one-byte first row
    task automatic test_stride(input logic [1:0] sz, input logic col, input int stride);
        do_reset();
        seq_en = 1'b0;
        size_sel_i = sz; color_i = col;
        pulse_req();
        lead_in();
        step(1'b1, 1'b0, 8'hA7);
        step(1'b0, 1'b0, 8'h00);
        chk(wr_en_o == 1'b1 && wr_data_o == 8'hA7, "R11", "write one edge after sample",
            int'(wr_data_o), 8'hA7);
        chk(wr_addr_o == 20'd0, "R11", "first address of frame", int'(wr_addr_o), 0);
        step(1'b0, 1'b0, 8'h00);
        chk(wr_en_o == 1'b0, "R5", "no write for blank byte", wr_en_o, 0);
        step(1'b1, 1'b0, 8'hC3);
        step(1'b0, 1'b0, 8'h00);
        chk(wr_en_o == 1'b1 && int'(wr_addr_o) == stride, "R3", "second row start address",
            int'(wr_addr_o), stride);
        chk(wr_data_o == 8'hC3, "R4", "second row data", int'(wr_data_o), 8'hC3);
        seq_en = 1'b1;
    endtask

    initial begin
        test_reset();
        test_gray_small();
        test_colour_small();
        test_qqvga_overrun();
        test_restart();
        test_stride(2'b10, 1'b0, 320);
        test_stride(2'b11, 1'b1, 1280);
        test_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule